// File: doc/BRIEF.md
# Fault Monitor and Hiccup Sequencer

This block sits in the digital core of a synchronous buck controller. Digitized readings arrive from the converters: bias supply, input supply, die temperature, feedback and soft-start voltage. The block compares each reading with thresholds held as digital codes. It decides when the power stage must be stopped and when a restart may be tried. Voltage codes are 10 mV per LSB. Temperature codes are 1 °C per LSB.

When any protection check trips, two commands assert at once: the soft-start and compensation discharge command, and the gate-drivers-off command. The block then stays in a faulted idle state for a fixed number of clock ticks. At the end of that idle period the block leaves the faulted state only if the supply and thermal checks are valid. A short circuit does not block the restart. A persistent short therefore produces one restart attempt per idle period. A status output records which class of fault caused the last shutdown.

Top module: `hiccup_fault_sequencer`

## Requirements
- R1: Under reset, and just after it, fault_o, discharge_o and drivers_off_o are 1 and cause_o is 0. With valid readings, fault_o falls at exactly the IDLE_TICKS-th rising clock edge after reset is released.
- R2: The bias-supply check trips when vbias_i < 405, and clears only when vbias_i > 425. Between these two values it keeps its previous state.
- R3: The input-supply check trips when vin_i < 220, and clears only when vin_i > 250. Between these two values it keeps its previous state.
- R4: The thermal check trips when temp_i >= 145, and clears only when temp_i <= 135. Between these two values it keeps its previous state.
- R5: The short check trips when min(ss_i, 80) - fb_i > 25. It is evaluated only while the block is running.
- R6: A tripping reading is sampled at a rising edge. discharge_o and drivers_off_o are 1 after that same edge. fault_o is 1 after the next edge.
- R7: After a shutdown, fault_o stays 1 for at least IDLE_TICKS cycles. It stays 1 after that for as long as the bias, input or thermal check is tripped. If such a check is still tripped when the idle period ends, that check wins and the block stays faulted.
- R8: A persistent short causes repeated restarts, one every IDLE_TICKS+1 cycles. Each restart lasts one cycle. discharge_o stays 1 throughout.
- R9: cause_o is loaded at each shutdown. Bit 0 is set when either supply check tripped, bit 1 when the thermal check tripped, and bit 2 when the short check tripped. Several bits may be set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vbias_i | input | CODE_W | Bias supply reading, 10 mV/LSB |
| vin_i | input | CODE_W | Input supply reading, 10 mV/LSB |
| temp_i | input | CODE_W | Die temperature reading, 1 °C/LSB |
| fb_i | input | CODE_W | Feedback reading, 10 mV/LSB |
| ss_i | input | CODE_W | Soft-start reading, 10 mV/LSB |
| fault_o | output | 1 | Faulted idle state is active |
| discharge_o | output | 1 | Discharge command for the soft-start and compensation nodes |
| drivers_off_o | output | 1 | Hold both gate drivers low |
| cause_o | output | 3 | Fault class of the last shutdown: bit 2 short, bit 1 thermal, bit 0 supply |

## Verification
The assertions assume that every reading is a settled code that changes only between clock edges. They also assume that IDLE_TICKS is at least 2. The checks on the hysteresis bands and on the restart condition assume the readings stay fixed across each sampling edge. The stimulus meets this by changing inputs only on the falling edge. It holds each reading for at least one full cycle and returns to a nominal set of readings between cases. The nominal set lies clear of every threshold.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  localparam int CODE_W_DEF = 10;

  // voltages in 10 mV codes, temperature in 1 C codes
  localparam int VBIAS_TRIP_DEF  = 405;
  localparam int VBIAS_CLEAR_DEF = 425;
  localparam int VIN_TRIP_DEF    = 220;
  localparam int VIN_CLEAR_DEF   = 250;
  localparam int HOT_TRIP_DEF    = 145;
  localparam int HOT_CLEAR_DEF   = 135;
  localparam int VREF_DEF        = 80;
  localparam int SHORT_OFS_DEF   = 25;

  typedef struct packed {
    logic short_c;
    logic therm_c;
    logic supply_c;
  } cause_t;

  typedef enum logic {ST_HOLD = 1'b0, ST_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/hyst_cmp.sv
module hyst_cmp #(
  parameter int CODE_W    = 10,
  parameter bit TRIP_HIGH = 1'b0,
  parameter int TRIP_THR  = 405,
  parameter int CLEAR_THR = 425
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              flag_o
);
  localparam logic [CODE_W-1:0] TRIP_C  = CODE_W'(TRIP_THR);
  localparam logic [CODE_W-1:0] CLEAR_C = CODE_W'(CLEAR_THR);

  logic trip, clear;

  generate
    if (TRIP_HIGH) begin : g_over
      assign trip  = code_i >= TRIP_C;
      assign clear = code_i <= CLEAR_C;
    end else begin : g_under
      assign trip  = code_i < TRIP_C;
      assign clear = code_i > CLEAR_C;
    end
  endgenerate

  // starts tripped so a valid reading is needed first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b1;
    else if (trip)   flag_o <= 1'b1;
    else if (clear)  flag_o <= 1'b0;
  end

  // R2 R3 R4: inside the band the flag keeps its value
  p_band_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trip && !clear) |=> $stable(flag_o));
  // R2 R3 R4: a tripping reading always yields a set flag
  p_trip_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip |=> flag_o);
endmodule

// File: rtl/short_det.sv
module short_det #(
  parameter int CODE_W = 10,
  parameter int VREF   = 80,
  parameter int OFS    = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] fb_i,
  input  logic [CODE_W-1:0] ss_i,
  output logic              short_o
);
  localparam logic [CODE_W-1:0] VREF_C = CODE_W'(VREF);
  localparam logic [CODE_W:0]   OFS_C  = (CODE_W+1)'(OFS);

  logic [CODE_W-1:0] act_ref;
  logic [CODE_W:0]   fb_lim;
  logic              below;

  // soft-start overrides the fixed reference while it is lower
  assign act_ref = (ss_i < VREF_C) ? ss_i : VREF_C;
  assign fb_lim  = {1'b0, fb_i} + OFS_C;
  assign below   = fb_lim < {1'b0, act_ref};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) short_o <= 1'b0;
    else         short_o <= below;
  end

  // R5: feedback at or above both references never flags a short
  p_no_false_short_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_i >= ss_i || fb_i >= VREF_C) |=> !short_o);
endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl
  import hiccup_pkg::*;
#(
  parameter int IDLE_TICKS = 20_000_000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   supply_f_i,
  input  logic   therm_f_i,
  input  logic   short_f_i,
  output logic   fault_o,
  output logic   off_o,
  output cause_t cause_o
);
  localparam int CNT_W = (IDLE_TICKS > 2) ? $clog2(IDLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_TICKS - 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              running, blocking, trip, expired;

  assign running  = state_q == ST_RUN;
  assign blocking = supply_f_i | therm_f_i;
  // short counts only while switching; in hold it is treated as cleared
  assign trip     = blocking | (running & short_f_i);
  assign expired  = cnt_q == LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      cause_o <= '0;
    end else if (running) begin
      if (trip) begin
        state_q <= ST_HOLD;
        cnt_q   <= '0;
        cause_o <= '{short_c: short_f_i, therm_c: therm_f_i, supply_c: supply_f_i};
      end
    end else if (!expired) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (!blocking) begin
      // set-dominant: a live supply/thermal fault keeps the latch set
      state_q <= ST_RUN;
    end
  end

  assign fault_o = !running;
  assign off_o   = !running | trip;

  // R7: restart only from an expired timer with supply and thermal valid
  p_release_cond_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && (blocking || !expired)) |=> !running);
  // R6: a trip while running always ends the run
  p_trip_stops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && trip) |=> fault_o);
  // R9: every shutdown records at least one class
  p_cause_loaded_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running) |-> (cause_o != '0));
  // R7: timer restarts from zero on entry to hold
  p_timer_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running) |-> (cnt_q == '0));
endmodule

// File: rtl/hiccup_fault_sequencer.sv
module hiccup_fault_sequencer
  import hiccup_pkg::*;
#(
  parameter int CODE_W      = CODE_W_DEF,
  parameter int IDLE_TICKS  = 20_000_000,
  parameter int VBIAS_TRIP  = VBIAS_TRIP_DEF,
  parameter int VBIAS_CLEAR = VBIAS_CLEAR_DEF,
  parameter int VIN_TRIP    = VIN_TRIP_DEF,
  parameter int VIN_CLEAR   = VIN_CLEAR_DEF,
  parameter int HOT_TRIP    = HOT_TRIP_DEF,
  parameter int HOT_CLEAR   = HOT_CLEAR_DEF,
  parameter int VREF        = VREF_DEF,
  parameter int SHORT_OFS   = SHORT_OFS_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] vbias_i,
  input  logic [CODE_W-1:0] vin_i,
  input  logic [CODE_W-1:0] temp_i,
  input  logic [CODE_W-1:0] fb_i,
  input  logic [CODE_W-1:0] ss_i,
  output logic              fault_o,
  output logic              discharge_o,
  output logic              drivers_off_o,
  output logic [2:0]        cause_o
);
  logic   vbias_f, vin_f, hot_f, short_f, off;
  cause_t cause;

  hyst_cmp #(.CODE_W(CODE_W), .TRIP_HIGH(1'b0), .TRIP_THR(VBIAS_TRIP), .CLEAR_THR(VBIAS_CLEAR))
    u_vbias (.clk_i, .rst_ni, .code_i(vbias_i), .flag_o(vbias_f));

  hyst_cmp #(.CODE_W(CODE_W), .TRIP_HIGH(1'b0), .TRIP_THR(VIN_TRIP), .CLEAR_THR(VIN_CLEAR))
    u_vin (.clk_i, .rst_ni, .code_i(vin_i), .flag_o(vin_f));

  hyst_cmp #(.CODE_W(CODE_W), .TRIP_HIGH(1'b1), .TRIP_THR(HOT_TRIP), .CLEAR_THR(HOT_CLEAR))
    u_hot (.clk_i, .rst_ni, .code_i(temp_i), .flag_o(hot_f));

  short_det #(.CODE_W(CODE_W), .VREF(VREF), .OFS(SHORT_OFS))
    u_short (.clk_i, .rst_ni, .fb_i, .ss_i, .short_o(short_f));

  hiccup_ctrl #(.IDLE_TICKS(IDLE_TICKS))
    u_ctrl (.clk_i, .rst_ni, .supply_f_i(vbias_f | vin_f), .therm_f_i(hot_f),
            .short_f_i(short_f), .fault_o, .off_o(off), .cause_o(cause));

  assign discharge_o   = off;
  assign drivers_off_o = off;
  assign cause_o       = cause;

  // R6: the discharge and driver commands never disagree, and cover the hold
  p_cmd_cover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (discharge_o && drivers_off_o));
  // R1: reset is inactive only after the first edge; outputs start faulted
  p_reset_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> fault_o);
endmodule

// File: tb/hiccup_fault_sequencer_test.sv
module hiccup_fault_sequencer_test;
  localparam int W = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] vbias, vin, temp, fb, ss;
  logic fault, disch, drv_off;
  logic [2:0] cause;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  hiccup_fault_sequencer #(.CODE_W(W), .IDLE_TICKS(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .vbias_i(vbias), .vin_i(vin), .temp_i(temp),
    .fb_i(fb), .ss_i(ss), .fault_o(fault), .discharge_o(disch),
    .drivers_off_o(drv_off), .cause_o(cause));

  // {vbias, vin, temp, fb, ss, expect_trip, expect_cause}
  localparam int VW = 5*W + 4;
  localparam logic [VW-1:0] VEC [12] = '{
    {10'd500, 10'd300, 10'd50,  10'd80, 10'd100, 1'b0, 3'b000},
    {10'd404, 10'd300, 10'd50,  10'd80, 10'd100, 1'b1, 3'b001},
    {10'd405, 10'd300, 10'd50,  10'd80, 10'd100, 1'b0, 3'b000},
    {10'd500, 10'd219, 10'd50,  10'd80, 10'd100, 1'b1, 3'b001},
    {10'd500, 10'd220, 10'd50,  10'd80, 10'd100, 1'b0, 3'b000},
    {10'd500, 10'd300, 10'd145, 10'd80, 10'd100, 1'b1, 3'b010},
    {10'd500, 10'd300, 10'd144, 10'd80, 10'd100, 1'b0, 3'b000},
    {10'd500, 10'd300, 10'd50,  10'd54, 10'd100, 1'b1, 3'b100},
    {10'd500, 10'd300, 10'd50,  10'd55, 10'd100, 1'b0, 3'b000},
    {10'd500, 10'd300, 10'd50,  10'd14, 10'd40,  1'b1, 3'b100},
    {10'd500, 10'd300, 10'd50,  10'd15, 10'd40,  1'b0, 3'b000},
    {10'd300, 10'd300, 10'd150, 10'd80, 10'd100, 1'b1, 3'b011}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [W-1:0] a, b, c, d, e);
    vbias = a; vin = b; temp = c; fb = d; ss = e;
  endtask

  task automatic nominal();
    drive(10'd500, 10'd300, 10'd50, 10'd80, 10'd100);
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // trip, then an in-band reading must keep it faulted, then a clearing one releases
  task automatic band_case(input logic [5*W-1:0] t, b, c, input string req);
    drive(t[49:40], t[39:30], t[29:20], t[19:10], t[9:0]);
    step(1);
    check(disch == 1'b1, req, disch, 1);
    drive(b[49:40], b[39:30], b[29:20], b[19:10], b[9:0]);
    step(2*N);
    check(fault == 1'b1, req, fault, 1);
    drive(c[49:40], c[39:30], c[29:20], c[19:10], c[9:0]);
    step(2);
    check(fault == 1'b0 && disch == 1'b0, req, {fault, disch}, 0);
    step(2);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    nominal();
    step(2);
    // R1: reset state
    check(fault && disch && drv_off, "R1 reset outputs", {fault, disch, drv_off}, 7);
    check(cause == 3'b000, "R1 reset cause", cause, 0);
    rst_ni = 1'b1;
    step(N - 1);
    check(fault == 1'b1, "R1 still idle", fault, 1);
    step(1);
    check(fault == 1'b0, "R1 release at IDLE_TICKS", fault, 0);

    // R2 R3 R4 R5 R6 R9: table walk from the running state
    for (int i = 0; i < 12; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[53:44], v[43:34], v[33:24], v[23:14], v[13:4]);
      step(1);
      check(disch == v[3], $sformatf("R6 vec %0d discharge", i), disch, v[3]);
      check(drv_off == v[3], $sformatf("R6 vec %0d drivers_off", i), drv_off, v[3]);
      step(1);
      check(fault == v[3], $sformatf("R2 R3 R4 R5 vec %0d fault", i), fault, v[3]);
      if (v[3]) check(cause == v[2:0], $sformatf("R9 vec %0d cause", i), cause, v[2:0]);
      nominal();
      step(N + 4);
      check(fault == 1'b0, $sformatf("R7 vec %0d recovered", i), fault, 0);
    end

    // R2 R7: bias band holds the fault past the idle period
    band_case({10'd400, 10'd300, 10'd50, 10'd80, 10'd100},
              {10'd410, 10'd300, 10'd50, 10'd80, 10'd100},
              {10'd426, 10'd300, 10'd50, 10'd80, 10'd100}, "R2 R7 bias band");
    // R3: input band
    band_case({10'd500, 10'd200, 10'd50, 10'd80, 10'd100},
              {10'd500, 10'd250, 10'd50, 10'd80, 10'd100},
              {10'd500, 10'd251, 10'd50, 10'd80, 10'd100}, "R3 input band");
    // R4: thermal band
    band_case({10'd500, 10'd300, 10'd150, 10'd80, 10'd100},
              {10'd500, 10'd300, 10'd136, 10'd80, 10'd100},
              {10'd500, 10'd300, 10'd135, 10'd80, 10'd100}, "R4 thermal band");

    // R8: persistent short retries periodically
    begin
      int runs, dlow;
      runs = 0; dlow = 0;
      drive(10'd500, 10'd300, 10'd50, 10'd0, 10'd100);
      for (int k = 0; k < 3*(N+1); k++) begin
        step(1);
        if (!fault) runs++;
        if (!disch) dlow++;
      end
      check(runs == 3, "R8 restart attempts", runs, 3);
      check(dlow == 0, "R8 discharge held", dlow, 0);
      check(cause == 3'b100, "R8 R9 short cause", cause, 4);
      nominal();
      step(N + 4);
      check(fault == 1'b0, "R8 recovery", fault, 0);
    end

    report();
  end
endmodule